// File: doc/BRIEF.md
# SPI Interrupt Vector Encoder

This block gathers every interrupt source of an SPI controller and turns it into two small vector codes that a CPU reads to learn why it was interrupted. Status events (four error kinds and a fifth error kind, receive overrun, receive buffer full, transmit buffer empty) are latched in a flag register. In buffered mode, completion and suspend events from the transfer groups are latched as well. Each source is gated by an enable bit and then sent to one of two interrupt lines by a level bit. For each line, a priority encoder builds a 6-bit vector. Bits 5:1 hold the code and bit 0 marks a group suspend. The line's interrupt output is high whenever that vector is nonzero.

The serial engine, the buffer RAM and the group sequencer are outside this block. They deliver one-cycle event pulses. Software uses a plain register bus to set up the block, read the vectors and clear flags by writing ones. Reading a vector also acknowledges the source it reports when that source is receive-full, transmit-empty or a transfer group. The CPU reads a vector and branches on it. A value from 0x01 to 0x21 is a group event. A larger value is a status source, and the flag register tells which error occurred.

Top module: `spi_irq_vector`

## Requirements
- R1: After a synchronous active-low reset, the flag register, all enable and level bits and the buffered-mode bit are 0, both vectors read 0, and `irq_hi` and `irq_lo` are low.
- R2: Status sources encode as full vector values: any error gives 0x22, receive overrun gives 0x26, receive full gives 0x24 and transmit empty gives 0x28. Bit 0 is 0 for all of them.
- R3: When the buffered-mode bit (CTRL bit 0) is 1, a completion from group N encodes as 2*(N+1) and a suspend from group N encodes as 2*(N+1)+1. When that bit is 0, group events are discarded and are not latched.
- R4: The flag register (address 3) uses these bit positions: bits 4:0 are the error kinds, bit 6 is overrun, bit 8 is receive full and bit 9 is transmit empty. All other bits read 0. Writing a 1 to a bit clears it. An event that arrives in the same cycle as the clearing write wins, so the bit stays set.
- R5: A read of a vector that returns 0x24 or 0x28 clears flag bit 8 or bit 9. A read that returns a group code clears that group's pending completion (or its suspend, when bit 0 is set). A read that returns 0x22 or 0x26 clears nothing.
- R6: A status source whose enable bit is 0 (source-enable register, address 1, same bit positions as the flags) still sets its flag but does not appear in either vector. A group whose bit in the group-enable register (address 6) is 0 is likewise kept out of both vectors.
- R7: A level bit of 0 (address 2 for status sources, address 7 for groups, bit N for group N) sends the source to vector 0 (address 4) and `irq_hi`. A level bit of 1 sends it to vector 1 (address 5) and `irq_lo`.
- R8: Within one line, the priority order is error, then overrun, then receive full, then transmit empty, then groups. Among groups the lowest number wins, and within a group a completion wins over a suspend.
- R9: `irq_hi` is high exactly when vector 0 is nonzero, and `irq_lo` is high exactly when vector 1 is nonzero.
- R10: `rdata` updates on the clock edge at which `rd_en` is sampled and holds the addressed register, zero-extended. Configuration registers read back the value last written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data, registered |
| err_evt | input | 5 | Error event pulses, one per error kind |
| rx_ovr_evt | input | 1 | Receive overrun pulse |
| rx_full_evt | input | 1 | Receive buffer full pulse |
| tx_empty_evt | input | 1 | Transmit buffer empty pulse |
| grp_done_evt | input | NG | Transfer group completion pulses |
| grp_susp_evt | input | NG | Transfer group suspend pulses |
| irq_hi | output | 1 | High-level interrupt line |
| irq_lo | output | 1 | Low-level interrupt line |

## Verification
The assertions check several properties on every cycle. A clearing write removes a flag unless an event arrives in the same cycle. A receive-full read acknowledges its flag. Group events are never latched outside buffered mode, and a group code never appears in a vector while that mode is off. A transmit-empty code appears on the high line only when that source is enabled, routed there, and nothing of higher priority is pending. The bench's scenarios are needed for the rest: the exact code values, the drain order when several sources are pending together, the effect of the level bits on which line rises, the lowest-group and completion-before-suspend ordering, and the fact that error and overrun codes survive repeated reads.

// File: rtl/spi_irq_pkg.sv
// Package: shared encodings for the SPI interrupt vector encoder.
// Assumes a data width of at least 10 bits so that every flag position fits.
package spi_irq_pkg;
    typedef enum logic [2:0] {
        A_CTRL    = 3'd0,
        A_SRC_EN  = 3'd1,
        A_SRC_LVL = 3'd2,
        A_FLAGS   = 3'd3,
        A_VEC_HI  = 3'd4,
        A_VEC_LO  = 3'd5,
        A_GRP_EN  = 3'd6,
        A_GRP_LVL = 3'd7
    } reg_addr_e;

    localparam int           ERR_KINDS = 5;
    localparam int           BIT_OVR   = 6;
    localparam int           BIT_RXF   = 8;
    localparam int           BIT_TXE   = 9;
    localparam logic [15:0]  FLAG_MASK = 16'h035F;

    localparam logic [5:0]   VEC_ERR   = 6'h22;
    localparam logic [5:0]   VEC_RXF   = 6'h24;
    localparam logic [5:0]   VEC_OVR   = 6'h26;
    localparam logic [5:0]   VEC_TXE   = 6'h28;
    localparam logic [5:0]   VEC_GRP_MAX = 6'h21;
endpackage

// File: rtl/spi_irq_flags.sv
// Module: status flag register.
// Holds the latched status events. Bits are cleared by a write-one-to-clear
// access or by an acknowledge mask coming from a vector read. A new event in
// the same cycle as a clear wins. Bits outside FLAG_MASK always stay 0.
module spi_irq_flags
    import spi_irq_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] evt_set,
    input  logic          w1c_en,
    input  logic [DW-1:0] w1c_data,
    input  logic [DW-1:0] ack_clr,
    output logic [DW-1:0] flags_q
);
    localparam logic [DW-1:0] MASK = DW'(FLAG_MASK);

    logic [DW-1:0] clr_all;

    // Merge the software clear with the read acknowledge.
    always_comb clr_all = (w1c_en ? w1c_data : '0) | ack_clr;

    // Update the flags: clear first, then set, then keep only valid bits.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= ((flags_q & ~clr_all) | evt_set) & MASK;
    end

    // R4: a written one clears its bit unless an event arrived in that cycle
    a_r4_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        w1c_en |=> ((flags_q & $past(w1c_data & ~evt_set)) == '0));

    // R1: flags are empty in the cycle after reset
    a_r1_reset_empty: assert property (@(posedge clk)
        !rst_n |=> (flags_q == '0));
endmodule

// File: rtl/spi_irq_groups.sv
// Module: pending completion and suspend events of the transfer groups.
// Events are latched only in buffered mode. A pending bit is cleared when
// a vector read reports it.
module spi_irq_groups #(
    parameter int NG = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          buf_mode,
    input  logic [NG-1:0] done_evt,
    input  logic [NG-1:0] susp_evt,
    input  logic [NG-1:0] clr_done,
    input  logic [NG-1:0] clr_susp,
    output logic [NG-1:0] done_q,
    output logic [NG-1:0] susp_q
);
    logic [NG-1:0] done_set, susp_set;

    // Discard group events outside buffered mode.
    always_comb begin
        done_set = buf_mode ? done_evt : '0;
        susp_set = buf_mode ? susp_evt : '0;
    end

    // Latch and acknowledge the pending group events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= '0;
            susp_q <= '0;
        end else begin
            done_q <= (done_q & ~clr_done) | done_set;
            susp_q <= (susp_q & ~clr_susp) | susp_set;
        end
    end

    // R3: no new group event is latched while buffered mode is off
    a_r3_compat_no_latch: assert property (@(posedge clk) disable iff (!rst_n)
        !buf_mode |=> (((done_q & ~$past(done_q)) == '0) &&
                       ((susp_q & ~$past(susp_q)) == '0)));
endmodule

// File: rtl/spi_irq_encoder.sv
// Module: fixed-priority vector encoder for one interrupt line.
// Inputs are already enabled and routed to this line. The group codes are
// used only in buffered mode. Assumes NG <= 16, so a group code never
// goes above 0x21.
module spi_irq_encoder
    import spi_irq_pkg::*;
#(
    parameter int NG = 8
) (
    input  logic          buf_mode,
    input  logic          err_req,
    input  logic          ovr_req,
    input  logic          rxf_req,
    input  logic          txe_req,
    input  logic [NG-1:0] done_req,
    input  logic [NG-1:0] susp_req,
    output logic [5:0]    vec
);
    // Choose the winning source: status sources first, then the lowest group.
    always_comb begin
        vec = '0;
        if (buf_mode) begin
            for (int g = NG - 1; g >= 0; g--) begin
                if (susp_req[g]) vec = {5'(g + 1), 1'b1};
                if (done_req[g]) vec = {5'(g + 1), 1'b0};
            end
        end
        if (err_req)      vec = VEC_ERR;
        else if (ovr_req) vec = VEC_OVR;
        else if (rxf_req) vec = VEC_RXF;
        else if (txe_req) vec = VEC_TXE;
    end
endmodule

// File: rtl/spi_irq_vector.sv
// Module: SPI interrupt vector encoder (top).
// Holds the configuration registers and the register bus. It latches status
// and group events, then builds one vector per interrupt line. Reading a
// vector acknowledges receive-full, transmit-empty and group sources.
// Assumes DW >= 10 and 1 <= NG <= 16. rdata is registered.
module spi_irq_vector
    import spi_irq_pkg::*;
#(
    parameter int DW = 16,
    parameter int NG = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [2:0]    addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic [4:0]    err_evt,
    input  logic          rx_ovr_evt,
    input  logic          rx_full_evt,
    input  logic          tx_empty_evt,
    input  logic [NG-1:0] grp_done_evt,
    input  logic [NG-1:0] grp_susp_evt,
    output logic          irq_hi,
    output logic          irq_lo
);
    logic              buf_mode_q;
    logic [DW-1:0]     src_en_q, src_lvl_q;
    logic [NG-1:0]     grp_en_q, grp_lvl_q;
    logic [DW-1:0]     flags_q, evt_set, ack_clr;
    logic [NG-1:0]     done_q, susp_q, clr_done, clr_susp;
    logic [1:0][5:0]   vec_w;
    logic              rd_vec;
    logic [5:0]        sel_vec;

    // Place the event pulses at their flag bit positions.
    always_comb begin
        evt_set = '0;
        evt_set[ERR_KINDS-1:0] = err_evt;
        evt_set[BIT_OVR]       = rx_ovr_evt;
        evt_set[BIT_RXF]       = rx_full_evt;
        evt_set[BIT_TXE]       = tx_empty_evt;
    end

    // Write the configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_mode_q <= 1'b0;
            src_en_q   <= '0;
            src_lvl_q  <= '0;
            grp_en_q   <= '0;
            grp_lvl_q  <= '0;
        end else if (wr_en) begin
            case (reg_addr_e'(addr))
                A_CTRL:    buf_mode_q <= wdata[0];
                A_SRC_EN:  src_en_q   <= wdata;
                A_SRC_LVL: src_lvl_q  <= wdata;
                A_GRP_EN:  grp_en_q   <= wdata[NG-1:0];
                A_GRP_LVL: grp_lvl_q  <= wdata[NG-1:0];
                default: ;
            endcase
        end
    end

    // Select the vector the current read is looking at.
    always_comb begin
        rd_vec  = rd_en && (addr == A_VEC_HI || addr == A_VEC_LO);
        sel_vec = (addr == A_VEC_LO) ? vec_w[1] : vec_w[0];
    end

    // Turn a vector read into acknowledge masks.
    always_comb begin
        ack_clr  = '0;
        clr_done = '0;
        clr_susp = '0;
        if (rd_vec) begin
            if (sel_vec == VEC_RXF) ack_clr[BIT_RXF] = 1'b1;
            if (sel_vec == VEC_TXE) ack_clr[BIT_TXE] = 1'b1;
            if (buf_mode_q && sel_vec != '0 && sel_vec <= VEC_GRP_MAX) begin
                for (int g = 0; g < NG; g++) begin
                    if (sel_vec[5:1] == 5'(g + 1)) begin
                        clr_done[g] = !sel_vec[0];
                        clr_susp[g] = sel_vec[0];
                    end
                end
            end
        end
    end

    spi_irq_flags #(.DW(DW)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_set  (evt_set),
        .w1c_en   (wr_en && addr == A_FLAGS),
        .w1c_data (wdata),
        .ack_clr  (ack_clr),
        .flags_q  (flags_q)
    );

    spi_irq_groups #(.NG(NG)) u_groups (
        .clk      (clk),
        .rst_n    (rst_n),
        .buf_mode (buf_mode_q),
        .done_evt (grp_done_evt),
        .susp_evt (grp_susp_evt),
        .clr_done (clr_done),
        .clr_susp (clr_susp),
        .done_q   (done_q),
        .susp_q   (susp_q)
    );

    // One gated, routed encoder per interrupt line (0 = high, 1 = low).
    for (genvar l = 0; l < 2; l++) begin : g_line
        localparam logic ON_LINE = (l == 1);
        logic [ERR_KINDS-1:0] err_sel;
        logic [NG-1:0]        grp_sel;
        logic                 ovr_r, rxf_r, txe_r;

        // Apply the enable and level gating for this line.
        always_comb begin
            for (int b = 0; b < ERR_KINDS; b++)
                err_sel[b] = flags_q[b] && src_en_q[b] && (src_lvl_q[b] == ON_LINE);
            ovr_r = flags_q[BIT_OVR] && src_en_q[BIT_OVR] && (src_lvl_q[BIT_OVR] == ON_LINE);
            rxf_r = flags_q[BIT_RXF] && src_en_q[BIT_RXF] && (src_lvl_q[BIT_RXF] == ON_LINE);
            txe_r = flags_q[BIT_TXE] && src_en_q[BIT_TXE] && (src_lvl_q[BIT_TXE] == ON_LINE);
            for (int g = 0; g < NG; g++)
                grp_sel[g] = grp_en_q[g] && (grp_lvl_q[g] == ON_LINE);
        end

        spi_irq_encoder #(.NG(NG)) u_enc (
            .buf_mode (buf_mode_q),
            .err_req  (|err_sel),
            .ovr_req  (ovr_r),
            .rxf_req  (rxf_r),
            .txe_req  (txe_r),
            .done_req (done_q & grp_sel),
            .susp_req (susp_q & grp_sel),
            .vec      (vec_w[l])
        );
    end

    // Drive an interrupt line while its vector is nonzero.
    always_comb begin
        irq_hi = (vec_w[0] != '0);
        irq_lo = (vec_w[1] != '0);
    end

    // Capture the read data for the addressed register.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else if (rd_en) begin
            case (reg_addr_e'(addr))
                A_CTRL:    rdata <= DW'(buf_mode_q);
                A_SRC_EN:  rdata <= src_en_q;
                A_SRC_LVL: rdata <= src_lvl_q;
                A_FLAGS:   rdata <= flags_q;
                A_VEC_HI:  rdata <= DW'(vec_w[0]);
                A_VEC_LO:  rdata <= DW'(vec_w[1]);
                A_GRP_EN:  rdata <= DW'(grp_en_q);
                default:   rdata <= DW'(grp_lvl_q);
            endcase
        end
    end

    // R5: reading a receive-full code acknowledges the receive-full flag
    a_r5_rd_acks_rxf: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_vec && sel_vec == VEC_RXF && !rx_full_evt) |=> !flags_q[BIT_RXF]);

    // R6 and R7: a transmit-empty code on the high line needs that source enabled and routed there
    a_r6_txe_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_w[0] == VEC_TXE) |-> (src_en_q[BIT_TXE] && !src_lvl_q[BIT_TXE]));

    // R8: transmit-empty is reported only when nothing above it is pending on that line
    a_r8_txe_lowest_status: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_w[0] == VEC_TXE) |->
            !((flags_q[BIT_RXF] && src_en_q[BIT_RXF] && !src_lvl_q[BIT_RXF]) ||
              (flags_q[BIT_OVR] && src_en_q[BIT_OVR] && !src_lvl_q[BIT_OVR])));

    // R3: a group-range code exists only in buffered mode
    a_r3_group_needs_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_w[1] != '0 && vec_w[1] <= VEC_GRP_MAX) |-> buf_mode_q);
endmodule

// File: tb/spi_irq_vector_bench.sv
// Scoreboard bench: the driver tasks queue expected read data, and a
// monitor compares each one when the read data appears.
module spi_irq_vector_bench;
    localparam int DW = 16;
    localparam int NG = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0]    addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic [4:0]    err_evt = '0;
    logic          rx_ovr_evt = 1'b0, rx_full_evt = 1'b0, tx_empty_evt = 1'b0;
    logic [NG-1:0] grp_done_evt = '0, grp_susp_evt = '0;
    logic          irq_hi, irq_lo;

    typedef struct { logic [DW-1:0] exp; string tag; } exp_t;
    exp_t   sb_q[$];
    int     n_checks = 0;
    int     n_fails  = 0;
    logic   rd_pend  = 1'b0;
    bit     finished = 1'b0;

    always #2 clk = ~clk;

    spi_irq_vector #(.DW(DW), .NG(NG)) u_spi_irq_vector (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .err_evt(err_evt), .rx_ovr_evt(rx_ovr_evt),
        .rx_full_evt(rx_full_evt), .tx_empty_evt(tx_empty_evt),
        .grp_done_evt(grp_done_evt), .grp_susp_evt(grp_susp_evt),
        .irq_hi(irq_hi), .irq_lo(irq_lo)
    );

    // Remember that a read was sampled at this edge.
    always @(posedge clk) rd_pend <= rd_en;

    // Monitor: compare the read data with the oldest expected item.
    always @(negedge clk) begin
        if (rd_pend && sb_q.size() > 0) begin
            exp_t it;
            it = sb_q.pop_front();
            n_checks++;
            if (rdata !== it.exp) begin
                n_fails++;
                $display("FAIL %s: rdata=0x%04h expected 0x%04h", it.tag, rdata, it.exp);
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [DW-1:0] e, input string tag);
        exp_t it;
        @(negedge clk); rd_en = 1'b1; addr = a;
        it.exp = e; it.tag = tag; sb_q.push_back(it);
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic pulse(input logic [4:0] e, input logic o, input logic rf, input logic te,
                         input logic [NG-1:0] gd, input logic [NG-1:0] gs);
        @(negedge clk);
        err_evt = e; rx_ovr_evt = o; rx_full_evt = rf; tx_empty_evt = te;
        grp_done_evt = gd; grp_susp_evt = gs;
        @(negedge clk);
        err_evt = '0; rx_ovr_evt = 1'b0; rx_full_evt = 1'b0; tx_empty_evt = 1'b0;
        grp_done_evt = '0; grp_susp_evt = '0;
    endtask

    task automatic chk_bit(input logic act, input logic exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk_bit(irq_hi, 1'b0, "R1 irq_hi");
        chk_bit(irq_lo, 1'b0, "R1 irq_lo");
        rd(3'd3, 16'h0000, "R1 flags");
        rd(3'd4, 16'h0000, "R1 vec0");
        rd(3'd5, 16'h0000, "R1 vec1");
        rd(3'd0, 16'h0000, "R1 ctrl");

        wr(3'd1, 16'h035F);
        // R2 and R9: transmit empty
        pulse(5'd0, 0, 0, 1, '0, '0);
        chk_bit(irq_hi, 1'b1, "R9 irq_hi on");
        chk_bit(irq_lo, 1'b0, "R9 irq_lo off");
        rd(3'd4, 16'h0028, "R2 txe code");
        rd(3'd3, 16'h0000, "R5 txe acked");
        chk_bit(irq_hi, 1'b0, "R9 irq_hi off");
        // R2: receive full
        pulse(5'd0, 0, 1, 0, '0, '0);
        rd(3'd4, 16'h0024, "R2 rxf code");
        rd(3'd3, 16'h0000, "R5 rxf acked");
        // R2 and R5: overrun survives reads, R4 clears it
        pulse(5'd0, 1, 0, 0, '0, '0);
        rd(3'd4, 16'h0026, "R2 ovr code");
        rd(3'd4, 16'h0026, "R5 ovr not acked");
        rd(3'd3, 16'h0040, "R4 ovr bit6");
        wr(3'd3, 16'h0040);
        rd(3'd4, 16'h0000, "R4 ovr cleared");
        // R2 and R4: error kind at bit 2
        pulse(5'b00100, 0, 0, 0, '0, '0);
        rd(3'd3, 16'h0004, "R4 err bit2");
        rd(3'd4, 16'h0022, "R2 err code");
        rd(3'd4, 16'h0022, "R5 err not acked");
        wr(3'd3, 16'hFFFF);
        rd(3'd3, 16'h0000, "R4 w1c all");
        // R8: all status sources at once drain in priority order
        pulse(5'b00001, 1, 1, 1, '0, '0);
        rd(3'd3, 16'h0341, "R4 all flags");
        rd(3'd4, 16'h0022, "R8 err first");
        wr(3'd3, 16'h0001);
        rd(3'd4, 16'h0026, "R8 ovr second");
        wr(3'd3, 16'h0040);
        rd(3'd4, 16'h0024, "R8 rxf third");
        rd(3'd4, 16'h0028, "R8 txe fourth");
        rd(3'd4, 16'h0000, "R8 drained");
        // R7: transmit empty routed to the low line
        wr(3'd2, 16'h0200);
        pulse(5'd0, 0, 0, 1, '0, '0);
        chk_bit(irq_lo, 1'b1, "R7 irq_lo");
        chk_bit(irq_hi, 1'b0, "R7 irq_hi");
        rd(3'd4, 16'h0000, "R7 vec0 empty");
        rd(3'd5, 16'h0028, "R7 vec1 txe");
        rd(3'd3, 16'h0000, "R7 acked via vec1");
        wr(3'd2, 16'h0000);
        // R6: a disabled source sets its flag but no vector
        wr(3'd1, 16'h0000);
        pulse(5'd0, 0, 1, 0, '0, '0);
        chk_bit(irq_hi, 1'b0, "R6 irq_hi quiet");
        rd(3'd3, 16'h0100, "R6 flag set");
        rd(3'd4, 16'h0000, "R6 vec0 quiet");
        wr(3'd1, 16'h035F);
        rd(3'd4, 16'h0024, "R6 enabled later");
        rd(3'd3, 16'h0000, "R6 acked");
        // R4: an event in the same cycle as a clearing write wins
        @(negedge clk);
        wr_en = 1'b1; addr = 3'd3; wdata = 16'h0004; err_evt = 5'b00100;
        @(negedge clk);
        wr_en = 1'b0; err_evt = '0;
        rd(3'd3, 16'h0004, "R4 set wins");
        wr(3'd3, 16'h0004);
        rd(3'd3, 16'h0000, "R4 cleared after");
        // R3: group events ignored outside buffered mode
        wr(3'd6, 16'h00FF);
        pulse(5'd0, 0, 0, 0, 8'h08, '0);
        rd(3'd4, 16'h0000, "R3 compat no code");
        wr(3'd0, 16'h0001);
        rd(3'd4, 16'h0000, "R3 not latched");
        // R3 and R5: group 3 completion
        pulse(5'd0, 0, 0, 0, 8'h08, '0);
        rd(3'd4, 16'h0008, "R3 grp3 done");
        rd(3'd4, 16'h0000, "R5 grp acked");
        // R8: the lowest group wins
        pulse(5'd0, 0, 0, 0, 8'h20, 8'h01);
        rd(3'd4, 16'h0003, "R8 grp0 susp");
        rd(3'd4, 16'h000C, "R8 grp5 done");
        rd(3'd4, 16'h0000, "R8 groups drained");
        // R8: completion before suspend within one group
        pulse(5'd0, 0, 0, 0, 8'h02, 8'h02);
        rd(3'd4, 16'h0004, "R8 grp1 done first");
        rd(3'd4, 16'h0005, "R8 grp1 susp next");
        // R3: last group suspend is the largest group code
        pulse(5'd0, 0, 0, 0, '0, 8'h80);
        rd(3'd4, 16'h0011, "R3 grp7 susp");
        // R7: group routed to the low line
        wr(3'd7, 16'h0004);
        pulse(5'd0, 0, 0, 0, 8'h04, '0);
        chk_bit(irq_lo, 1'b1, "R7 grp irq_lo");
        rd(3'd4, 16'h0000, "R7 grp vec0 empty");
        rd(3'd5, 16'h0006, "R7 grp2 on vec1");
        // R8: status before groups
        pulse(5'd0, 0, 0, 1, 8'h01, '0);
        rd(3'd4, 16'h0028, "R8 txe over group");
        rd(3'd4, 16'h0002, "R8 grp0 after");
        rd(3'd4, 16'h0000, "R8 empty");
        // R10: configuration readback
        rd(3'd0, 16'h0001, "R10 ctrl");
        rd(3'd1, 16'h035F, "R10 src_en");
        rd(3'd6, 16'h00FF, "R10 grp_en");
        rd(3'd7, 16'h0004, "R10 grp_lvl");
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule